// File: doc/BRIEF.md
# Two-Dimensional Strided Beat Address Generator

This block produces the address of every bus beat of a rectangular memory transfer: a number of rows, each a fixed number of bytes long, with the start of each row placed a programmable stride beyond the start of the row before it. A stride larger than the row length skips a gap between rows. A stride equal to the row length gives one contiguous run. The generator offers one address per beat on a valid/ready interface. It marks the last beat of every row and the final beat of the whole transfer.

Software sets up a small configuration register set: start address, row length, row count and row stride. Both lengths are written as the value minus one. Each register reads back only the bits the instance implements, so a driver can find the alignment, the maximum length and whether two-dimensional support exists by writing probe values and reading them back. A single-cycle start pulse copies the configuration into the running transfer. One instance serves the read side of a copy engine and a second instance serves the write side.

Top module: `agen_2d`

## Requirements
- R1: The row-length register (select 1) holds bytes per row minus one in XLEN_W bits. Its low log2(BEAT_BYTES) bits always read as one, so writing 0 reads back BEAT_BYTES-1 (the alignment mask). Writing all ones reads back 2^XLEN_W-1. Bits above XLEN_W read as zero.
- R2: Within a row, each accepted beat advances the address by BEAT_BYTES. A row has (row-length register + 1) / BEAT_BYTES beats.
- R3: The row-count register (select 2) holds rows minus one. Each row starts at the previous row's start plus the stride register (select 3). A transfer has (row-length + 1) x (row-count + 1) bytes.
- R4: The start-address register (select 0) and the stride register read back with their low log2(BEAT_BYTES) bits cleared, and every beat address is aligned to BEAT_BYTES.
- R5: row_end is high on the last beat of each row. done is high, together with row_end, only on the last beat of the last row. Both are low while idle.
- R6: A start pulse while busy is ignored, and register writes during a transfer do not change it.
- R7: busy and beat_valid rise in the cycle after a start pulse and fall in the cycle after the final beat is accepted. While beat_ready is low, the address and markers hold.
- R8: With HAS_2D = 0, the row-count and stride registers read zero (a written 1 is not kept) and every transfer is a single row.
- R9: After reset the generator is idle with beat_valid low, the start address and stride read 0, the row count reads 0, and the row length reads BEAT_BYTES-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 address, 1 row length, 2 row count, 3 stride |
| cfg_wdata | input | DATA_W | Configuration write data |
| cfg_rdata | output | DATA_W | Read-back of the selected register |
| start | input | 1 | Start pulse; ignored while busy |
| busy | output | 1 | Transfer in progress |
| beat_valid | output | 1 | Beat address available |
| beat_ready | input | 1 | Beat accepted when high with beat_valid |
| beat_addr | output | ADDR_W | Current beat byte address |
| row_end | output | 1 | Current beat is the last of its row |
| done | output | 1 | Current beat is the last of the transfer |

## Verification
The hardest situation to reach from the ports is a start pulse and a register write that arrive in the middle of a transfer, while the consumer is stalling. The bench reaches it by firing start and a base-address write on the second beat of a multi-row transfer. It then checks that every later address still follows the latched geometry. The row-to-row jump under stalls is covered by vectors whose ready patterns drop the handshake on different beats, including on the beat that closes a row. A second instance built without two-dimensional support shares all inputs, so probes and transfers compare both variants under the same stimulus.

// File: rtl/agen_pkg.sv
package agen_pkg;
   typedef enum logic [1:0] {
      REG_BASE   = 2'd0,
      REG_XLEN   = 2'd1,
      REG_YLEN   = 2'd2,
      REG_STRIDE = 2'd3
   } agen_reg_e;
endpackage

// File: rtl/agen_cfg_regs.sv
module agen_cfg_regs
   import agen_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int XLEN_W     = 12,
   parameter int YLEN_W     = 8,
   parameter int STRIDE_W   = 16,
   parameter int BEAT_BYTES = 8,
   parameter bit HAS_2D     = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [1:0]          sel,
   input  logic [DATA_W-1:0]   wdata,
   output logic [DATA_W-1:0]   rdata,
   output logic [ADDR_W-1:0]   base_o,
   output logic [XLEN_W-1:0]   xlen_o,
   output logic [YLEN_W-1:0]   ylen_o,
   output logic [STRIDE_W-1:0] stride_o
);
   localparam int SH = $clog2(BEAT_BYTES);
   localparam logic [XLEN_W-1:0] ALIGN_MASK = XLEN_W'(BEAT_BYTES - 1);

   logic [ADDR_W-1:0] base_q;
   logic [XLEN_W-1:0] xlen_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         xlen_q <= ALIGN_MASK;
      end else if (we) begin
         if (sel == REG_BASE) base_q <= {wdata[ADDR_W-1:SH], {SH{1'b0}}};
         if (sel == REG_XLEN) xlen_q <= wdata[XLEN_W-1:0] | ALIGN_MASK;
      end
   end

   generate
      if (HAS_2D) begin : g_2d
         logic [YLEN_W-1:0]   ylen_q;
         logic [STRIDE_W-1:0] stride_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ylen_q   <= '0;
               stride_q <= '0;
            end else if (we) begin
               if (sel == REG_YLEN)   ylen_q   <= wdata[YLEN_W-1:0];
               if (sel == REG_STRIDE) stride_q <= {wdata[STRIDE_W-1:SH], {SH{1'b0}}};
            end
         end
         assign ylen_o   = ylen_q;
         assign stride_o = stride_q;
      end else begin : g_1d
         assign ylen_o   = '0;
         assign stride_o = '0;
      end
   endgenerate

   assign base_o = base_q;
   assign xlen_o = xlen_q;

   always_comb begin
      rdata = '0;
      unique case (sel)
         REG_BASE:   rdata[ADDR_W-1:0]   = base_q;
         REG_XLEN:   rdata[XLEN_W-1:0]   = xlen_q;
         REG_YLEN:   rdata[YLEN_W-1:0]   = ylen_o;
         REG_STRIDE: rdata[STRIDE_W-1:0] = stride_o;
         default:    rdata = '0;
      endcase
   end
endmodule

// File: rtl/agen_wrap_ctr.sv
module agen_wrap_ctr #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         step,
   input  logic [W-1:0] last_val,
   output logic         at_last
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) cnt_q <= '0;
      else if (step)     cnt_q <= at_last ? '0 : cnt_q + W'(1);
   end

   assign at_last = (cnt_q == last_val);
endmodule

// File: rtl/agen_addr_path.sv
module agen_addr_path #(
   parameter int ADDR_W     = 32,
   parameter int BEAT_BYTES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] base_in,
   input  logic [ADDR_W-1:0] stride_in,
   input  logic              adv,
   input  logic              row_wrap,
   output logic [ADDR_W-1:0] addr_o
);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BEAT_BYTES);

   logic [ADDR_W-1:0] row_base_q, stride_q, cur_q, next_base;

   assign next_base = row_base_q + stride_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row_base_q <= '0;
         stride_q   <= '0;
         cur_q      <= '0;
      end else if (load) begin
         row_base_q <= base_in;
         stride_q   <= stride_in;
         cur_q      <= base_in;
      end else if (adv) begin
         if (row_wrap) begin
            row_base_q <= next_base;
            cur_q      <= next_base;
         end else begin
            cur_q <= cur_q + STEP;
         end
      end
   end

   assign addr_o = cur_q;
endmodule

// File: rtl/agen_2d.sv
module agen_2d #(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int XLEN_W     = 12,
   parameter int YLEN_W     = 8,
   parameter int STRIDE_W   = 16,
   parameter int BEAT_BYTES = 8,
   parameter bit HAS_2D     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   input  logic              start,
   output logic              busy,
   output logic              beat_valid,
   input  logic              beat_ready,
   output logic [ADDR_W-1:0] beat_addr,
   output logic              row_end,
   output logic              done
);
   localparam int SH     = $clog2(BEAT_BYTES);
   localparam int BEAT_W = XLEN_W - SH;

   generate
      if (BEAT_BYTES < 2 || (1 << SH) != BEAT_BYTES) begin : g_bad_beat
         $error("agen_2d: BEAT_BYTES must be a power of two of at least 2");
      end
      if (XLEN_W <= SH || STRIDE_W <= SH) begin : g_bad_len
         $error("agen_2d: XLEN_W and STRIDE_W must exceed log2(BEAT_BYTES)");
      end
      if (DATA_W < ADDR_W || ADDR_W < STRIDE_W || DATA_W < XLEN_W || DATA_W < YLEN_W) begin : g_bad_w
         $error("agen_2d: register widths exceed data or address width");
      end
   endgenerate

   logic [ADDR_W-1:0]   cfg_base;
   logic [XLEN_W-1:0]   cfg_xlen;
   logic [YLEN_W-1:0]   cfg_ylen;
   logic [STRIDE_W-1:0] cfg_stride;

   agen_cfg_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .XLEN_W(XLEN_W), .YLEN_W(YLEN_W),
      .STRIDE_W(STRIDE_W), .BEAT_BYTES(BEAT_BYTES), .HAS_2D(HAS_2D)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
      .rdata(cfg_rdata), .base_o(cfg_base), .xlen_o(cfg_xlen), .ylen_o(cfg_ylen),
      .stride_o(cfg_stride)
   );

   logic              busy_q, launch, fire, beat_last, row_last;
   logic [BEAT_W-1:0] beats_last_q;
   logic [YLEN_W-1:0] rows_last_q;

   assign launch = start & ~busy_q;
   assign fire   = busy_q & beat_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q       <= 1'b0;
         beats_last_q <= '0;
         rows_last_q  <= '0;
      end else if (launch) begin
         busy_q       <= 1'b1;
         beats_last_q <= cfg_xlen[XLEN_W-1:SH];
         rows_last_q  <= cfg_ylen;
      end else if (fire && done) begin
         busy_q <= 1'b0;
      end
   end

   agen_wrap_ctr #(.W(BEAT_W)) u_beat_ctr (
      .clk(clk), .rst_n(rst_n), .clr(launch), .step(fire),
      .last_val(beats_last_q), .at_last(beat_last)
   );

   agen_wrap_ctr #(.W(YLEN_W)) u_row_ctr (
      .clk(clk), .rst_n(rst_n), .clr(launch), .step(fire & beat_last),
      .last_val(rows_last_q), .at_last(row_last)
   );

   agen_addr_path #(.ADDR_W(ADDR_W), .BEAT_BYTES(BEAT_BYTES)) u_addr (
      .clk(clk), .rst_n(rst_n), .load(launch), .base_in(cfg_base),
      .stride_in(ADDR_W'(cfg_stride)), .adv(fire), .row_wrap(beat_last),
      .addr_o(beat_addr)
   );

   assign busy       = busy_q;
   assign beat_valid = busy_q;
   assign row_end    = busy_q & beat_last;
   assign done       = busy_q & beat_last & row_last;
endmodule

// File: rtl/agen_2d_chk.sv
module agen_2d_chk #(
   parameter int ADDR_W     = 32,
   parameter int BEAT_BYTES = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              beat_valid,
   input logic              beat_ready,
   input logic [ADDR_W-1:0] beat_addr,
   input logic              row_end,
   input logic              done
);
   localparam int SH = $clog2(BEAT_BYTES);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BEAT_BYTES);

   AST_DONE_WITH_ROW_END: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> row_end); // R5
   AST_IDLE_NO_MARKERS: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!row_end && !done)); // R5
   AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      beat_valid |-> (beat_addr[SH-1:0] == '0)); // R4
   AST_STEP_IN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && beat_ready && !row_end) |=> (beat_addr == $past(beat_addr) + STEP)); // R2
   AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_addr) && $stable(row_end))); // R7
   AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && beat_ready && done) |=> !busy); // R7
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !(beat_ready && done)) |=> busy); // R6
endmodule

bind agen_2d agen_2d_chk #(.ADDR_W(ADDR_W), .BEAT_BYTES(BEAT_BYTES)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .beat_valid(beat_valid),
   .beat_ready(beat_ready), .beat_addr(beat_addr), .row_end(row_end), .done(done)
);

// File: tb/sim_agen_2d.sv
module sim_agen_2d;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = 2'd0;
   logic [31:0] cfg_wdata = '0;
   logic        start = 1'b0;
   logic        beat_ready = 1'b0;
   logic [31:0] rd0, rd1, addr0, addr1;
   logic        busy0, valid0, rend0, done0, busy1, valid1, rend1, done1;
   int          checks = 0;
   int          errors = 0;

   always #2 clk = ~clk;

   agen_2d u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .cfg_rdata(rd0), .start(start), .busy(busy0), .beat_valid(valid0),
      .beat_ready(beat_ready), .beat_addr(addr0), .row_end(rend0), .done(done0)
   );

   agen_2d #(.HAS_2D(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .cfg_rdata(rd1), .start(start), .busy(busy1), .beat_valid(valid1),
      .beat_ready(beat_ready), .beat_addr(addr1), .row_end(rend1), .done(done1)
   );

   // {base, row length-1, rows-1, stride, stall period (0 = always ready)}
   localparam logic [95:0] VEC [5] = '{
      {32'h0000_1000, 16'd63, 16'd2, 16'h0100, 16'd0},
      {32'h0000_2004, 16'd0,  16'd3, 16'h0040, 16'd3},
      {32'h0000_3000, 16'd31, 16'd0, 16'h0200, 16'd2},
      {32'h0000_4000, 16'd15, 16'd4, 16'h0010, 16'd4},
      {32'hFFFF_FFC0, 16'd31, 16'd1, 16'h0020, 16'd5}
   };

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [31:0] d);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] sel, output logic [31:0] v0, output logic [31:0] v1);
      cfg_sel = sel;
      #1;
      v0 = rd0; v1 = rd1;
   endtask

   task automatic run(input logic [31:0] a, input logic [15:0] x, input logic [15:0] y,
                      input logic [15:0] s, input int stall, input bit poke);
      logic [31:0] base, cur, stride;
      int bpr, rows, bx, by, cyc;
      bit fin, rdy, lastb;
      wr(2'd0, a); wr(2'd1, {16'd0, x}); wr(2'd2, {16'd0, y}); wr(2'd3, {16'd0, s});
      base = a & ~32'd7; cur = base; stride = {16'd0, s & 16'hFFF8};
      bpr = int'(((x & 16'h0FFF) | 16'd7) >> 3) + 1;
      rows = int'(y & 16'h00FF) + 1;
      bx = 0; by = 0; cyc = 0; fin = 1'b0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy0 && valid0, "R7 busy after start", {62'd0, busy0, valid0}, 64'd3);
      while (!fin && cyc < 20000) begin
         rdy = (stall == 0) ? 1'b1 : ((cyc % stall) != 0);
         beat_ready = rdy;
         lastb = (bx == bpr - 1);
         chk(valid0 && addr0 == cur, "R2 R3 beat address", {32'd0, addr0}, {32'd0, cur});
         chk(rend0 == lastb && done0 == (lastb && by == rows - 1), "R5 markers",
             {62'd0, rend0, done0}, {62'd0, lastb, lastb && by == rows - 1});
         if (poke && cyc == 1) begin
            start = 1'b1; cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 32'h0000_7770; // R6
         end
         @(negedge clk);
         start = 1'b0; cfg_we = 1'b0;
         if (rdy) begin
            if (lastb) begin
               bx = 0;
               if (by == rows - 1) fin = 1'b1;
               else begin by++; base = base + stride; cur = base; end
            end else begin
               bx++; cur = cur + 32'd8;
            end
         end
         cyc++;
      end
      beat_ready = 1'b0;
      chk(!busy0 && !valid0, "R7 busy drops after final beat", {62'd0, busy0, valid0}, 64'd0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      logic [31:0] v0, v1;
      int n0, n1, re1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R9 reset state
      chk(!busy0 && !valid0 && !rend0 && !done0, "R9 idle after reset",
          {60'd0, busy0, valid0, rend0, done0}, 64'd0);
      rd(2'd0, v0, v1); chk(v0 == 32'd0, "R9 base", v0, 0);
      rd(2'd1, v0, v1); chk(v0 == 32'd7, "R9 row length", v0, 7);
      rd(2'd2, v0, v1); chk(v0 == 32'd0, "R9 row count", v0, 0);
      rd(2'd3, v0, v1); chk(v0 == 32'd0, "R9 stride", v0, 0);
      // R1 probes
      wr(2'd1, 32'd0);          rd(2'd1, v0, v1); chk(v0 == 32'd7, "R1 zero gives mask", v0, 7);
      wr(2'd1, 32'hFFFF_FFFF);  rd(2'd1, v0, v1); chk(v0 == 32'hFFF, "R1 all ones gives max", v0, 32'hFFF);
      wr(2'd1, 32'd100);        rd(2'd1, v0, v1); chk(v0 == 32'd103, "R1 low bits forced", v0, 103);
      // R4 alignment of base and stride
      wr(2'd0, 32'h0000_1235);  rd(2'd0, v0, v1); chk(v0 == 32'h1230, "R4 base aligned", v0, 32'h1230);
      wr(2'd3, 32'hFFFF_FFFF);  rd(2'd3, v0, v1); chk(v0 == 32'hFFF8, "R4 stride aligned", v0, 32'hFFF8);
      chk(v1 == 32'd0, "R8 stride absent", v1, 0);
      wr(2'd2, 32'hFFFF_FFFF);  rd(2'd2, v0, v1); chk(v0 == 32'hFF, "R3 row count width", v0, 32'hFF);
      wr(2'd2, 32'd1);          rd(2'd2, v0, v1); chk(v1 == 32'd0, "R8 row count not kept", v1, 0);
      // vector table
      for (int i = 0; i < 5; i++)
         run(VEC[i][95:64], VEC[i][63:48], VEC[i][47:32], VEC[i][31:16], int'(VEC[i][15:0]), 1'b0);
      // R6 start and base write in mid-transfer, with stalls
      run(32'h0000_5000, 16'd23, 16'd2, 16'h0080, 3, 1'b1);
      // R8 single row on the 1D instance, same stimulus
      wr(2'd0, 32'h0000_0500); wr(2'd1, 32'd31); wr(2'd2, 32'd2); wr(2'd3, 32'h100);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0; beat_ready = 1'b1;
      n0 = 0; n1 = 0; re1 = 0;
      for (int c = 0; c < 20; c++) begin
         if (valid0) n0++;
         if (valid1) begin
            n1++;
            if (rend1) re1++;
            if (n1 == 4) chk(done1 && addr1 == 32'h518, "R8 single-row end", {31'd0, done1, addr1}, {32'd1, 32'h518});
         end
         @(negedge clk);
      end
      beat_ready = 1'b0;
      chk(n1 == 4 && re1 == 1, "R8 one row of beats", {n1[31:0], re1[31:0]}, {32'd4, 32'd1});
      chk(n0 == 12, "R3 2D instance beats", n0, 12);
      chk(!busy0 && !busy1, "R7 both idle", {62'd0, busy0, busy1}, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule